// File: doc/BRIEF.md
# Width-Configurable Bus Address Sequencer

This block turns one processor access request into the address-phase signals of an external bus cycle. A request carries a byte address, an access size, a direction, an instruction/data flag, a burst length and the width of the memory region being addressed, which is 8, 16 or 32 bits. The block latches the request and drives a word address (byte address bits 31 down to 2). It also drives four active-low lane/address lines, a write/read line and a data/code line. All of these are held steady until the external side signals ready.

The meaning of the four lane lines depends on the region width. On a 32-bit region each line selects one byte lane. On a 16-bit region the lines become a high-byte select, a low-byte select and a plain copy of address bit 1. On an 8-bit region they carry address bits 1 and 0. Lines with no meaning are driven 0. A burst of up to four transfers steps only word-address bits 3:2, wrapping inside the aligned 16-byte block. The byte offset and the lane pattern are kept for every beat.

Top module: `busseq_addr_seq`

## Requirements
- R1: After reset the block is idle: `bus_active`=0, `bus_addr`=0, `bus_be_n`=4'b1111, `bus_wr`=0, `bus_dc`=0, `bus_last`=0 and `req_ready`=1. The same idle values appear whenever no burst is in progress.
- R2: A request is accepted on a rising edge where `req_valid`=1 and `req_ready`=1. From the next cycle `bus_active`=1, `req_ready`=0 and `bus_addr` equals `req_addr[31:2]`.
- R3: During a burst, `bus_wr` is 1 for a write request (`req_write`=1) and 0 for a read request. It stays unchanged through every beat of that burst.
- R4: During a burst, `bus_dc` is 1 for a data access (`req_data`=1) and 0 for an instruction fetch. It stays unchanged through every beat of that burst.
- R5: Region width code `req_width`=2'b10 or 2'b11 selects a 32-bit region. Size code `req_size` is 2'b00 for 1 byte, 2'b01 for 2 bytes, and 2'b10 or 2'b11 for 4 bytes. The block builds a selected-lane mask of 0001, 0011 or 1111 and shifts it left by `req_addr[1:0]`, dropping bits past lane 3. `bus_be_n[i]` is 0 exactly when lane i (data bits 8i+7:8i) is in the shifted mask.
- R6: On a 16-bit region (`req_width`=2'b01), `bus_be_n[3]` is a high-byte select, low when the size is not 1 byte or `req_addr[0]`=1. `bus_be_n[0]` is a low-byte select, low when the size is not 1 byte or `req_addr[0]`=0. `bus_be_n[1]` equals `req_addr[1]`, and `bus_be_n[2]` is 0.
- R7: On an 8-bit region (`req_width`=2'b00), `bus_be_n[1:0]` equals `req_addr[1:0]` and `bus_be_n[3:2]` is 0.
- R8: Each cycle with `bus_active`=1 and `bus_rdy`=1 on a non-final beat advances `bus_addr[1:0]` (address bits 3:2) by one modulo 4. The upper word-address bits and the `bus_be_n` pattern are left unchanged.
- R9: `req_beats` = L (0 to 3) gives L+1 beats. `bus_last` is 1 only during the final beat. A ready on the final beat returns the block to idle in the next cycle.
- R10: While `bus_active`=1 and `bus_rdy`=0, every bus output holds its value.
- R11: A request presented while a burst is in progress is ignored. It does not change `bus_addr`, `bus_be_n`, `bus_wr` or `bus_dc`, and the burst completes as first requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be accepted |
| req_addr | input | 32 | Byte address of the first beat |
| req_size | input | 2 | Access size code (R5) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_beats | input | 2 | Burst length minus one |
| req_width | input | 2 | Region width code |
| bus_rdy | input | 1 | External ready, completes the current beat |
| bus_active | output | 1 | Burst in progress |
| bus_last | output | 1 | Current beat is the final one |
| bus_addr | output | 30 | Word address, byte address bits 31:2 |
| bus_be_n | output | 4 | Width-dependent lane selects / address bits |
| bus_wr | output | 1 | Write/read qualifier |
| bus_dc | output | 1 | Data/code qualifier |

## Verification
A request accepted at one rising edge shows its first beat on the outputs in the cycle right after that edge. A ready sampled at a rising edge moves the outputs to the next beat in the following cycle. After the final beat, the idle values appear one cycle after its ready. The bench drives inputs just after a rising edge and samples outputs at the falling edge. A beat's expected values are therefore compared in every cycle it is shown. The beat is removed from the scoreboard only in the cycle where ready is high, so stalls and ignored requests are checked for holding steady.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  localparam int unsigned LANES = 4;
  localparam int unsigned OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    BW_8      = 2'd0,
    BW_16     = 2'd1,
    BW_32     = 2'd2,
    BW_32_ALT = 2'd3
  } bus_width_e;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_e;

endpackage

// File: rtl/busseq_lane_enc.sv
module busseq_lane_enc
  import busseq_pkg::*;
(
  input  bus_width_e       width_i,
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [LANES-1:0] en_n_o
);

  logic [LANES-1:0] size_mask;
  logic [LANES-1:0] wide_sel;
  logic [LANES-1:0] wide_n;
  logic [LANES-1:0] half_n;
  logic [LANES-1:0] byte_n;
  logic             multi_byte;
  logic             hi_sel;
  logic             lo_sel;

  // Lane mask for the access size, before alignment
  always_comb begin
    case (size_i)
      SZ_BYTE: size_mask = LANES'(1);
      SZ_HALF: size_mask = LANES'(3);
      default: size_mask = '1;
    endcase
  end

  assign wide_sel = size_mask << off_i;

  // Full-width region: one active-low select per byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wide_n[g] = ~wide_sel[g];
  end

  // Half-width region: high/low byte selects plus address bit 1
  assign multi_byte = (size_i != SZ_BYTE);
  assign hi_sel     = multi_byte | off_i[0];
  assign lo_sel     = multi_byte | ~off_i[0];
  assign half_n     = {~hi_sel, 1'b0, off_i[1], ~lo_sel};

  // Byte-wide region: low address bits, unused lines driven low
  assign byte_n = {2'b00, off_i};

  always_comb begin
    case (width_i)
      BW_8:    en_n_o = byte_n;
      BW_16:   en_n_o = half_n;
      default: en_n_o = wide_n;
    endcase
  end

endmodule

// File: rtl/busseq_burst_ctr.sv
module busseq_burst_ctr #(
  parameter int unsigned LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             adv_i,
  output logic [LEN_W-1:0] step_o,
  output logic             last_o
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] step_q, step_d;
  logic             upd_en;

  assign upd_en = load_i | adv_i;

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    step_d = step_q;
    if (load_i) begin
      cnt_d  = '0;
      len_d  = len_i;
      step_d = start_i;
    end else if (adv_i) begin
      cnt_d  = cnt_q + LEN_W'(1);
      step_d = step_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      step_q <= '0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      step_q <= step_d;
    end
  end

  assign step_o = step_q;
  assign last_o = (cnt_q == len_q);

  // Word-address step wraps inside the block on every advance
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (step_q == $past(step_q) + LEN_W'(1))); // R8

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (step_q == $past(start_i))); // R2

endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic rdy_i,
  input  logic last_i,
  output logic accept_o,
  output logic finish_o,
  output logic busy_o
);

  seq_state_e state_q, state_d;

  assign busy_o   = (state_q == ST_BUSY);
  assign accept_o = (state_q == ST_IDLE) & req_valid_i;
  assign finish_o = busy_o & rdy_i & last_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_BUSY;
      ST_BUSY: if (rdy_i && last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o); // R2

  AST_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rdy_i && last_i) |=> !busy_o); // R9

  AST_MID_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_i) |=> busy_o); // R9

endmodule

// File: rtl/busseq_addr_seq.sv
module busseq_addr_seq
  import busseq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_size,
  input  logic                      req_write,
  input  logic                      req_data,
  input  logic [BEAT_W-1:0]         req_beats,
  input  logic [1:0]                req_width,
  input  logic                      bus_rdy,
  output logic                      bus_active,
  output logic                      bus_last,
  output logic [ADDR_W-OFF_W-1:0]   bus_addr,
  output logic [LANES-1:0]          bus_be_n,
  output logic                      bus_wr,
  output logic                      bus_dc
);

  localparam int unsigned WORD_W = ADDR_W - OFF_W;
  localparam int unsigned HI_W   = WORD_W - BEAT_W;

  logic             accept;
  logic             finish;
  logic             busy;
  logic             last;
  logic [BEAT_W-1:0] step;
  logic [LANES-1:0] enc_n;

  logic [HI_W-1:0]  hi_q, hi_d;
  logic [OFF_W-1:0] off_q, off_d;
  acc_size_e        size_q, size_d;
  bus_width_e       width_q, width_d;
  logic             wr_q, wr_d;
  logic             dc_q, dc_d;

  busseq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .rdy_i       (bus_rdy),
    .last_i      (last),
    .accept_o    (accept),
    .finish_o    (finish),
    .busy_o      (busy)
  );

  busseq_burst_ctr #(.LEN_W(BEAT_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .start_i (req_addr[OFF_W +: BEAT_W]),
    .len_i   (req_beats),
    .adv_i   (busy & bus_rdy & ~finish),
    .step_o  (step),
    .last_o  (last)
  );

  // Request fields held for the whole burst
  always_comb begin
    hi_d    = hi_q;
    off_d   = off_q;
    size_d  = size_q;
    width_d = width_q;
    wr_d    = wr_q;
    dc_d    = dc_q;
    if (accept) begin
      hi_d    = req_addr[ADDR_W-1 -: HI_W];
      off_d   = req_addr[OFF_W-1:0];
      size_d  = acc_size_e'(req_size);
      width_d = bus_width_e'(req_width);
      wr_d    = req_write;
      dc_d    = req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      width_q <= BW_8;
      wr_q    <= 1'b0;
      dc_q    <= 1'b0;
    end else if (accept) begin
      hi_q    <= hi_d;
      off_q   <= off_d;
      size_q  <= size_d;
      width_q <= width_d;
      wr_q    <= wr_d;
      dc_q    <= dc_d;
    end
  end

  busseq_lane_enc u_lane (
    .width_i (width_q),
    .size_i  (size_q),
    .off_i   (off_q),
    .en_n_o  (enc_n)
  );

  assign req_ready  = ~busy;
  assign bus_active = busy;
  assign bus_last   = busy & last;
  assign bus_addr   = busy ? {hi_q, step} : '0;
  assign bus_be_n   = busy ? enc_n : '1;
  assign bus_wr     = busy & wr_q;
  assign bus_dc     = busy & dc_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !(bus_rdy && bus_last)) |=> $stable(bus_wr)); // R3

  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !(bus_rdy && bus_last)) |=> $stable(bus_dc)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_rdy) |=> ($stable(bus_addr) && $stable(bus_be_n))); // R10

  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_rdy && !bus_last) |=>
      (bus_addr[WORD_W-1:BEAT_W] == $past(bus_addr[WORD_W-1:BEAT_W]) && $stable(bus_be_n))); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && req_valid && !bus_rdy) |=> (bus_active && $stable(bus_wr) && $stable(bus_dc))); // R11

endmodule

// File: tb/busseq_addr_seq_bench.sv
module busseq_addr_seq_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [29:0] addr;
    logic [3:0]  be_n;
    logic        wr;
    logic        dc;
    logic        last;
    logic [1:0]  width;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_data = 1'b0;
  logic [1:0]  req_beats = '0;
  logic [1:0]  req_width = '0;
  logic        bus_rdy = 1'b0;
  logic        bus_active;
  logic        bus_last;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  logic        bus_wr;
  logic        bus_dc;

  int n_checks = 0;
  int n_errors = 0;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  busseq_addr_seq u_busseq_addr_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_data   (req_data),
    .req_beats  (req_beats),
    .req_width  (req_width),
    .bus_rdy    (bus_rdy),
    .bus_active (bus_active),
    .bus_last   (bus_last),
    .bus_addr   (bus_addr),
    .bus_be_n   (bus_be_n),
    .bus_wr     (bus_wr),
    .bus_dc     (bus_dc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected lane lines from R5, R6, R7
  function automatic logic [3:0] exp_be(input logic [1:0] w, input logic [1:0] sz,
                                        input logic [1:0] off);
    logic [3:0] mask;
    logic hi, lo;
    case (w)
      2'b00: return {2'b00, off};
      2'b01: begin
        hi = (sz != 2'b00) || off[0];
        lo = (sz != 2'b00) || !off[0];
        return {!hi, 1'b0, off[1], !lo};
      end
      default: begin
        mask = (sz == 2'b00) ? 4'b0001 : (sz == 2'b01) ? 4'b0011 : 4'b1111;
        return ~((mask << off) & 4'hF);
      end
    endcase
  endfunction

  // Driver: pushes expected beats, issues the request, paces ready
  task automatic run(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                     input logic dc, input logic [1:0] len, input logic [1:0] w,
                     input int stall, input logic poke);
    for (int k = 0; k <= int'(len); k++) begin
      beat_t b;
      logic [1:0] s;
      s = a[3:2] + 2'(k);
      b.addr  = {a[31:4], s};
      b.be_n  = exp_be(w, sz, a[1:0]);
      b.wr    = wr;
      b.dc    = dc;
      b.last  = (k == int'(len));
      b.width = w;
      exp_q.push_back(b);
    end
    @(posedge clk); #1;
    chk("R2 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_data = dc; req_beats = len; req_width = w;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int k = 0; k <= int'(len); k++) begin
      for (int j = 0; j < stall; j++) begin
        if (poke) begin
          // R11: conflicting request during the burst
          req_valid = 1'b1; req_addr = ~a; req_write = ~wr; req_data = ~dc;
          req_width = ~w; req_size = ~sz;
        end
        @(posedge clk); #1;
      end
      req_valid = 1'b0;
      bus_rdy = 1'b1;
      @(posedge clk); #1;
      bus_rdy = 1'b0;
    end
    @(negedge clk);
    chk("R9 idle after final beat", 32'(bus_active), 32'd0);
    chk("R1 idle lane lines", 32'(bus_be_n), 32'hF);
    chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
  endtask

  // Monitor: compares the head beat each active cycle, pops on ready
  always @(negedge clk) begin
    if (rst_n && bus_active) begin
      if (exp_q.size() == 0) begin
        chk("R11 unexpected activity", 32'(bus_active), 32'd0);
      end else begin
        beat_t e;
        e = exp_q[0];
        chk("R2 R8 word address", 32'(bus_addr), 32'(e.addr));
        case (e.width)
          2'b00:   chk("R7 byte-wide lines", 32'(bus_be_n), 32'(e.be_n));
          2'b01:   chk("R6 half-wide lines", 32'(bus_be_n), 32'(e.be_n));
          default: chk("R5 full-wide lanes", 32'(bus_be_n), 32'(e.be_n));
        endcase
        chk("R3 write/read", 32'(bus_wr), 32'(e.wr));
        chk("R4 data/code", 32'(bus_dc), 32'(e.dc));
        chk("R9 last beat", 32'(bus_last), 32'(e.last));
        chk("R11 busy not ready", 32'(req_ready), 32'd0);
        if (bus_rdy) void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset active", 32'(bus_active), 32'd0);
    chk("R1 reset address", 32'(bus_addr), 32'd0);
    chk("R1 reset lane lines", 32'(bus_be_n), 32'hF);
    chk("R1 reset wr/dc", 32'({bus_wr, bus_dc}), 32'd0);
    chk("R1 reset ready", 32'(req_ready), 32'd1);

    // R5: full-wide region, all offsets and sizes
    for (int o = 0; o < 4; o++) begin
      run(32'h1000_0000 | 32'(o), 2'b00, 1'b1, 1'b1, 2'd0, 2'b10, 0, 1'b0);
      run(32'h2000_0040 | 32'(o), 2'b01, 1'b0, 1'b1, 2'd0, 2'b11, 0, 1'b0);
    end
    run(32'hABCD_EF08, 2'b10, 1'b0, 1'b0, 2'd0, 2'b10, 0, 1'b0);
    // R6: half-wide region
    for (int o = 0; o < 4; o++) begin
      run(32'h3000_0010 | 32'(o), 2'b00, 1'b1, 1'b0, 2'd0, 2'b01, 0, 1'b0);
      run(32'h3000_0020 | 32'(o), 2'b01, 1'b0, 1'b1, 2'd0, 2'b01, 0, 1'b0);
    end
    // R7: byte-wide region
    for (int o = 0; o < 4; o++)
      run(32'h4000_0030 | 32'(o), 2'b00, 1'b1, 1'b1, 2'd0, 2'b00, 0, 1'b0);
    // R8 R9: bursts of each length, wrapping inside the 16-byte block
    run(32'h5000_0008, 2'b10, 1'b0, 1'b0, 2'd3, 2'b10, 0, 1'b0);
    run(32'h5000_004C, 2'b01, 1'b1, 1'b1, 2'd2, 2'b01, 0, 1'b0);
    run(32'hFFFF_FFF7, 2'b00, 1'b0, 1'b1, 2'd1, 2'b00, 0, 1'b0);
    // R10: stalls between beats
    run(32'h6000_0004, 2'b10, 1'b1, 1'b0, 2'd3, 2'b10, 3, 1'b0);
    // R11: conflicting requests during stalls
    run(32'h7000_0032, 2'b01, 1'b0, 1'b1, 2'd2, 2'b10, 2, 1'b1);
    run(32'h7100_0001, 2'b00, 1'b1, 1'b0, 2'd3, 2'b01, 1, 1'b1);

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule